// File: doc/BRIEF.md
# Page Write Staging Buffer

This block sits between a serial-memory front end and a byte-wide non-volatile storage array. A write transaction opens with a start address whose upper bits pick a page and whose lower bits pick the first byte offset inside that page. Data bytes then stream in, one per accepted handshake, each landing at the current offset before the offset steps forward. The offset wraps inside the page, so a long burst overwrites its own earlier bytes instead of spilling into the next page. Nothing reaches the array until the front end issues a commit, which it does on the bus stop condition.

On a commit with at least one byte loaded, the block walks the page's slots in ascending offset order, one slot per clock, and issues an array write for each slot that was loaded during the transaction. Untouched slots keep their previous array contents. An array fresh from the factory reads 0xFF everywhere, so those slots stay erased. After the walk, the block holds busy for a parameterised number of clocks that models the program time. While busy, the block ignores every control input. An abort discards the staged bytes, which is how a write-protect rejection reaches this block. A commit with nothing loaded, such as the address phase of a random read, is a no-op.

The load stream uses valid/ready. `ld_ready` is high only when the block is idle and no start, commit or abort is presented in the same cycle. A byte is taken when `ld_valid` and `ld_ready` are both high. A byte offered while `ld_ready` is low is not stored and is not held for later: the source must keep `ld_valid` up or drop the byte. The array port has no back-pressure, because the array accepts one write per clock.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and `ld_ready` is high. The transaction starts at address 0 with no bytes loaded.
- R2: When idle, a `start_valid` pulse does three things: page = `start_addr[ADDR_W-1:PAGE_W]`, offset = `start_addr[PAGE_W-1:0]`, and the loaded set is emptied. Priority among control inputs in one cycle is abort, then start, then commit.
- R3: `ld_ready` = not busy and none of `start_valid`, `commit`, `abort` high this cycle. An accepted byte is stored at the current offset, marked loaded, and the offset then increments by one.
- R4: The offset wraps from the last byte of the page to 0 within the same page. A later byte at an already loaded offset replaces the earlier one.
- R5: A commit accepted with at least one byte loaded raises `busy` from the next cycle. In cycle 1+i after the commit edge, slot i is presented. `arr_we` is high only for loaded slots, with `arr_addr` = {page, i} and `arr_wdata` = the last byte loaded at offset i.
- R6: `busy` stays high for exactly 2^PAGE_W + WR_CYCLES cycles after the commit edge. It then falls and the loaded set is empty.
- R7: A commit with no byte loaded leaves `busy` and `arr_we` low.
- R8: An abort while idle empties the loaded set without any array write. A following commit then starts no write.
- R9: While `busy` is high, `start_valid`, `ld_valid`, `commit` and `abort` have no effect. The current write proceeds unchanged, and no byte offered during busy is written later.
- R10: `arr_we` is never high except in the cycle after a cycle with `busy` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Begin a transaction at `start_addr` |
| start_addr | input | ADDR_W | Page select (upper bits) and first byte offset (lower PAGE_W bits) |
| ld_valid | input | 1 | A data byte is offered |
| ld_data | input | DATA_W | Offered data byte |
| ld_ready | output | 1 | Block accepts the offered byte this cycle |
| commit | input | 1 | End of transaction; program loaded bytes |
| abort | input | 1 | Discard the staged transaction |
| busy | output | 1 | Array write and program time in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array byte data |

## Verification
A wrong loaded-set bit shows at the array port as a missing write or a spurious write in the cycle that slot is walked, at most 2^PAGE_W cycles after the commit. A bad offset shows as the wrong byte at a slot address in that same walk. A stale page register shows as a wrong upper address on the first write. A wrong busy length shows within one cycle of the expected fall, as a `busy` or `ld_ready` mismatch. A per-cycle reference model catches each of these in the cycle it appears, and a read-back of every address the model wrote exposes any misplaced write.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_SCAN = 2'd1,
    DR_WAIT = 2'd2
  } drain_state_e;
endpackage

// File: rtl/pwb_stage.sv
module pwb_stage #(
  parameter int PAGE_W = 8,
  parameter int SEL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_start,
  input  logic [SEL_W+PAGE_W-1:0] start_addr,
  input  logic                    clr,
  input  logic                    ld_fire,
  input  logic [DATA_W-1:0]       ld_data,
  input  logic [PAGE_W-1:0]       rd_idx,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic [SEL_W-1:0]        page,
  output logic                    any_loaded
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_W-1:0]     off_q;
  logic [SEL_W-1:0]      page_q;

  always_ff @(posedge clk) begin
    if (ld_fire) buf_q[off_q] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      off_q  <= '0;
      page_q <= '0;
    end else if (set_start) begin
      mask_q <= '0;
      off_q  <= start_addr[PAGE_W-1:0];
      page_q <= start_addr[SEL_W+PAGE_W-1:PAGE_W];
    end else if (clr) begin
      mask_q <= '0;
    end else if (ld_fire) begin
      mask_q[off_q] <= 1'b1;
      off_q         <= off_q + 1'b1;
    end
  end

  assign rd_valid   = mask_q[rd_idx];
  assign rd_data    = buf_q[rd_idx];
  assign page       = page_q;
  assign any_loaded = |mask_q;

  p_load_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !set_start && !clr) |=> any_loaded);
  p_offset_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !set_start && !clr && off_q == '1) |=> (off_q == '0));
  p_start_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_start |=> !any_loaded);
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
  import pwb_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              scan_en,
  output logic [SLOT_W-1:0] scan_idx,
  output logic              done
);
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

  drain_state_e      state_q;
  logic [SLOT_W-1:0] idx_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DR_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        DR_IDLE: if (go) begin
          state_q <= DR_SCAN;
          idx_q   <= '0;
        end
        DR_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) begin
            state_q <= DR_WAIT;
            cnt_q   <= '0;
          end
        end
        DR_WAIT: begin
          if (cnt_q == CNT_LAST) state_q <= DR_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= DR_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != DR_IDLE);
  assign scan_en  = (state_q == DR_SCAN);
  assign scan_idx = idx_q;
  assign done     = (state_q == DR_WAIT) && (cnt_q == CNT_LAST);

  p_go_scans_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (scan_en && scan_idx == '0));
  p_done_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  input  logic              commit,
  input  logic              abort,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int SEL_W = ADDR_W - PAGE_W;

  logic              ctl_free, ab_f, st_f, cm_f, ld_fire, go, done;
  logic              rd_valid, any_loaded, scan_en;
  logic [DATA_W-1:0] rd_data;
  logic [SEL_W-1:0]  page;
  logic [PAGE_W-1:0] scan_idx;

  assign ctl_free = !busy;
  assign ab_f     = ctl_free && abort;
  assign st_f     = ctl_free && !abort && start_valid;
  assign cm_f     = ctl_free && !abort && !start_valid && commit;
  assign ld_ready = ctl_free && !abort && !start_valid && !commit;
  assign ld_fire  = ld_valid && ld_ready;
  assign go       = cm_f && any_loaded;

  pwb_stage #(.PAGE_W(PAGE_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .set_start(st_f), .start_addr(start_addr),
    .clr(ab_f || done), .ld_fire(ld_fire), .ld_data(ld_data),
    .rd_idx(scan_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .page(page), .any_loaded(any_loaded)
  );

  pwb_drain #(.SLOT_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_drain (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .scan_en(scan_en),
    .scan_idx(scan_idx), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we    <= scan_en && rd_valid;
      arr_addr  <= {page, scan_idx};
      arr_wdata <= rd_data;
    end
  end

  p_we_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(busy));
  p_write_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr[ADDR_W-1:PAGE_W] == page));
  p_empty_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy && !abort && !start_valid && !any_loaded) |=> !busy);
  p_abort_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !busy) |=> !any_loaded);
  p_page_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page));
  p_empty_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_loaded);
endmodule

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int PAGE_W = 8;
  localparam int DATA_W = 8;
  localparam int WR     = 20;
  localparam int SLOTS  = 1 << PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, ld_valid = 1'b0, commit = 1'b0, abort = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic ld_ready, busy, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  page_write_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                      .WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
    .commit(commit), .abort(abort), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [7:0] mbuf [SLOTS];
  bit       mmask [SLOTS];
  int       mpage = 0, moff = 0, mleft = 0, mdpos = 0;
  bit       e_we = 0;
  int       e_addr = 0, e_data = 0;
  bit [7:0] mmem [int];
  bit [7:0] dmem [int];

  function automatic bit m_any();
    for (int i = 0; i < SLOTS; i++) if (mmask[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mpage = 0; moff = 0; mleft = 0; mdpos = 0; e_we = 0;
      for (int i = 0; i < SLOTS; i++) mmask[i] = 0;
    end else if (mleft > 0) begin
      e_we = 0;
      if (mdpos < SLOTS) begin
        e_we = mmask[mdpos];
        e_addr = mpage * SLOTS + mdpos;
        e_data = mbuf[mdpos];
        if (e_we) mmem[e_addr] = e_data[7:0];
        mdpos++;
      end
      mleft--;
      if (mleft == 0) for (int i = 0; i < SLOTS; i++) mmask[i] = 0;
    end else begin
      e_we = 0;
      if (abort) begin
        for (int i = 0; i < SLOTS; i++) mmask[i] = 0;
      end else if (start_valid) begin
        mpage = int'(start_addr) / SLOTS;
        moff  = int'(start_addr) % SLOTS;
        for (int i = 0; i < SLOTS; i++) mmask[i] = 0;
      end else if (commit) begin
        if (m_any()) begin mleft = SLOTS + WR; mdpos = 0; end
      end else if (ld_valid) begin
        mbuf[moff] = ld_data; mmask[moff] = 1; moff = (moff + 1) % SLOTS;
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always begin
    @(negedge clk); #1;
    if (rst_n && !done_flag) begin
      bit eready;
      eready = (mleft == 0) && !abort && !start_valid && !commit;
      chk(busy == (mleft > 0), "busy (R6)", int'(busy), int'(mleft > 0));
      chk(ld_ready == eready, "ld_ready (R3)", int'(ld_ready), int'(eready));
      chk(arr_we == e_we, "arr_we (R5)", int'(arr_we), int'(e_we));
      if (arr_we && e_we) begin
        chk(int'(arr_addr) == e_addr, "arr_addr (R5)", int'(arr_addr), e_addr);
        chk(int'(arr_wdata) == e_data, "arr_wdata (R5)", int'(arr_wdata), e_data);
      end
      if (arr_we) dmem[int'(arr_addr)] = arr_wdata;
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic cyc(bit st, int sa, bit lv, int ld, bit cm, bit ab);
    start_valid = st; start_addr = ADDR_W'(sa); ld_valid = lv;
    ld_data = DATA_W'(ld); commit = cm; abort = ab;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wait_free();
    idle(1);
    while (busy) idle(1);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cur_req = "R1";
    chk(busy == 0, "busy after reset (R1)", int'(busy), 0);
    chk(ld_ready == 1, "ld_ready after reset (R1)", int'(ld_ready), 1);
    chk(arr_we == 0, "arr_we after reset (R1)", int'(arr_we), 0);
    @(negedge clk);

    // R2 R3 R5 R6: short burst mid-page
    cur_req = "R5";
    cyc(1, 'h12310, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 'hA0 + i, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    wait_free();

    // R4: wrap within the last page, 260 bytes
    cur_req = "R4";
    cyc(1, 'h1FFFE, 0, 0, 0, 0);
    for (int i = 0; i < 260; i++) cyc(0, 0, 1, (i * 7 + 3) & 'hFF, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    wait_free();

    // R7: address-only transaction
    cur_req = "R7";
    cyc(1, 'h00500, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    idle(10);
    chk(busy == 0, "busy after empty commit (R7)", int'(busy), 0);

    // R8: abort discards
    cur_req = "R8";
    cyc(1, 'h04020, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 'h55 + i, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0);
    idle(10);
    chk(busy == 0, "busy after aborted commit (R8)", int'(busy), 0);

    // R2 priority: start and commit together, start wins
    cur_req = "R2";
    cyc(1, 'h00A00, 0, 0, 0, 0);
    cyc(0, 0, 1, 'h11, 0, 0);
    cyc(1, 'h00B40, 0, 0, 1, 0);
    cyc(0, 0, 1, 'h22, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    wait_free();

    // R9 R10: activity while busy has no effect
    cur_req = "R9";
    cyc(1, 'h0C0F0, 0, 0, 0, 0);
    cyc(0, 0, 1, 'h77, 0, 0);
    cyc(0, 0, 1, 'h78, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 'h99, 0, 0);
    cyc(1, 'h1F000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, i, i % 5 == 0, 0);
    wait_free();
    cur_req = "R9";
    cyc(0, 0, 0, 0, 1, 0);
    idle(5);
    chk(busy == 0, "no leftover bytes after busy (R9)", int'(busy), 0);

    // read-back of array image, R5 R10
    cur_req = "R10";
    foreach (mmem[k]) begin
      chk(dmem.exists(k) && dmem[k] == mmem[k], "array byte (R10)",
          dmem.exists(k) ? int'(dmem[k]) : -1, int'(mmem[k]));
    end
    chk(dmem.size() == mmem.size(), "written address count (R10)", dmem.size(), mmem.size());
    cur_req = "R5";
    chk(!dmem.exists('h1230F), "slot before start untouched, stays erased (R5)",
        dmem.exists('h1230F) ? 1 : 0, 0);
    chk(dmem.exists('h12314) && dmem['h12314] == 8'hA4, "last burst byte (R5)",
        dmem.exists('h12314) ? int'(dmem['h12314]) : -1, 'hA4);
    finish_run();
  end
endmodule